// File: doc/BRIEF.md
# Private Interrupt Pending-State Tracker

This block keeps the pending and active state of the 32 interrupts that are private to one processor. Indices 0 to 15 are software-generated interrupts and indices 16 to 31 are per-processor peripheral interrupts. Each interrupt has its own four-state machine. Input lines raise the pending part of that state, either on a rising edge or for as long as a level is held. A processor acknowledge takes a pending interrupt into service. An end-of-interrupt strobe takes it out of service again.

Software reaches the block through a simple register port. A read at the register offset returns one pending flag per interrupt. A write at the same offset is write-one-to-clear on that pending state. Bits can be hidden from an access in two ways. A non-secure access cannot see or change interrupts of the secure group unless security is disabled. An interrupt whose security state does not have affinity routing enabled is also hidden. A software set-pending strobe gives level-sensitive interrupts a pending latch that does not depend on the line.

Top module: `irq_pend_track`

## Requirements
- R1: While reset is asserted and after it is released, every interrupt is inactive and `rdata_o` is zero. The two-bit state of interrupt x appears on `state_o[2x+1:2x]` as {active, pending}: inactive=00, pending=01, active=10, active-and-pending=11.
- R2: For an edge-sensitive interrupt (`level_i[x]`=0), a rising edge of `line_i[x]` makes an inactive interrupt pending. The edge is sampled at the clock and the state shows it in the next cycle. Holding the line high does not raise it again.
- R3: A register write with bit x of `wdata_i` set moves interrupt x from pending to inactive. Bits written as 0 leave their interrupts unchanged.
- R4: A clear write on an active-and-pending interrupt leaves it active. A clear write never removes the active state.
- R5: A clear write on an interrupt that is inactive or active has no effect.
- R6: The register port responds only when `addr_i` equals `REG_OFFSET` (0x280). A read there returns, one cycle after the request, bit x = 1 when interrupt x is pending or active-and-pending. A read at any other offset returns zero, a write at any other offset changes nothing, and `rdata_o` is zero in a cycle that follows no read.
- R7: A level-sensitive interrupt (`level_i[x]`=1) is pending while its line is high. A clear write does not remove this pending state. It ends one cycle after the line drops.
- R8: A `set_pend_i[x]` pulse sets a software latch that makes a level interrupt pending even with its line low. A clear write resets the latch, and the interrupt is then inactive unless the line is high.
- R9: An acknowledge of a pending interrupt makes it active. An acknowledge of an interrupt in any other state has no effect.
- R10: End-of-interrupt moves active to inactive and moves active-and-pending to pending. On an inactive interrupt it has no effect.
- R11: A new rising edge on an active edge-sensitive interrupt makes it active-and-pending.
- R12: When `sec_disable_i` is 0, a non-secure access (`ns_i`=1) reads secure-group bits (`secure_grp_i[x]`=1) as zero, and its writes to them are ignored. With `sec_disable_i` at 1, or with a secure access, these bits are visible and writable.
- R13: A bit whose security state has routing disabled reads as zero and ignores writes. The security state is selected by `secure_grp_i[x]`, which picks `route_en_s_i`, else `route_en_ns_i`.
- R14: When a rising edge or a set-pending pulse arrives in the same cycle as a clear write to the same interrupt, the interrupt ends up pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 32 | Interrupt input lines |
| level_i | input | 32 | 1 = level-sensitive, 0 = edge-sensitive, per interrupt |
| set_pend_i | input | 32 | Software set-pending strobes |
| secure_grp_i | input | 32 | 1 = interrupt belongs to the secure group |
| sec_disable_i | input | 1 | Security disabled: no filtering by access security |
| route_en_s_i | input | 1 | Affinity routing enabled for the secure state |
| route_en_ns_i | input | 1 | Affinity routing enabled for the non-secure state |
| ack_i | input | 1 | Acknowledge strobe |
| ack_id_i | input | 5 | Interrupt number acknowledged |
| eoi_i | input | 1 | End-of-interrupt strobe |
| eoi_id_i | input | 5 | Interrupt number completed |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| ns_i | input | 1 | 1 = non-secure access |
| addr_i | input | 12 | Register byte offset |
| wdata_i | input | 32 | Clear-pending write mask |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| state_o | output | 64 | Per-interrupt {active, pending} state |

## Verification
The hardest state to reach is active-and-pending. An interrupt must first become pending, then be acknowledged, and then see a second rising edge while it is still in service. The stimulus builds this path on both a software-generated index and a peripheral index. It then applies clear writes and end-of-interrupt strobes on that state, and repeats them on the states that follow. The collisions between a clear write and a hardware event in the same cycle are driven on one clock edge by hand. A level line is held high across a clear write to show that the write does not remove the pending state.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  // {active, pending}
  typedef enum logic [1:0] {
    ST_INACT   = 2'b00,
    ST_PEND    = 2'b01,
    ST_ACT     = 2'b10,
    ST_ACTPEND = 2'b11
  } irq_st_e;
endpackage

// File: rtl/irq_cell.sv
module irq_cell
  import irq_pend_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    line_i,
  input  logic    level_i,
  input  logic    set_i,
  input  logic    clr_i,
  input  logic    ack_i,
  input  logic    eoi_i,
  output irq_st_e st_o
);
  logic line_q, pend_q, sw_q, act_q;
  logic rise, pend_eff, take;

  assign rise     = line_i & ~line_q;
  assign pend_eff = level_i ? (line_q | sw_q) : pend_q;
  assign take     = ack_i & pend_eff & ~act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= 1'b0;
      pend_q <= 1'b0;
      sw_q   <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      line_q <= line_i;
      if (take)              act_q <= 1'b1;
      else if (eoi_i)        act_q <= 1'b0;
      // hardware set beats clear in the same cycle
      if (level_i)           pend_q <= 1'b0;
      else if (rise | set_i) pend_q <= 1'b1;
      else if (clr_i | take) pend_q <= 1'b0;
      if (!level_i)          sw_q <= 1'b0;
      else if (set_i)        sw_q <= 1'b1;
      else if (clr_i | take) sw_q <= 1'b0;
    end
  end

  assign st_o = irq_st_e'({act_q, pend_eff});
endmodule

// File: rtl/irq_pend_regs.sv
module irq_pend_regs #(
  parameter int unsigned N          = 32,
  parameter int unsigned ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h280
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              ns_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  input  logic              sec_disable_i,
  input  logic              route_en_s_i,
  input  logic              route_en_ns_i,
  input  logic [N-1:0]      secure_grp_i,
  input  logic [N-1:0]      pend_i,
  output logic [N-1:0]      clr_o,
  output logic [N-1:0]      rdata_o
);
  logic          hit;
  logic [N-1:0]  routed, blocked, acc, rdata_q;

  assign hit     = req_i && (addr_i == REG_OFFSET);
  assign routed  = (secure_grp_i & {N{route_en_s_i}}) | (~secure_grp_i & {N{route_en_ns_i}});
  assign blocked = secure_grp_i & {N{ns_i & ~sec_disable_i}};
  assign acc     = routed & ~blocked;
  assign clr_o   = (hit && we_i) ? (wdata_i & acc) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         rdata_q <= '0;
    else if (hit && !we_i) rdata_q <= pend_i & acc;
    else                 rdata_q <= '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_pend_track.sv
module irq_pend_track
  import irq_pend_pkg::*;
#(
  parameter int unsigned N_SGI      = 16,
  parameter int unsigned N_PPI      = 16,
  parameter int unsigned ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h280,
  localparam int unsigned N    = N_SGI + N_PPI,
  localparam int unsigned ID_W = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      line_i,
  input  logic [N-1:0]      level_i,
  input  logic [N-1:0]      set_pend_i,
  input  logic [N-1:0]      secure_grp_i,
  input  logic              sec_disable_i,
  input  logic              route_en_s_i,
  input  logic              route_en_ns_i,
  input  logic              ack_i,
  input  logic [ID_W-1:0]   ack_id_i,
  input  logic              eoi_i,
  input  logic [ID_W-1:0]   eoi_id_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              ns_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  output logic [N-1:0]      rdata_o,
  output logic [2*N-1:0]    state_o
);
  logic [N-1:0] pend, clr;

  irq_pend_regs #(.N(N), .ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .ns_i, .addr_i, .wdata_i,
    .sec_disable_i, .route_en_s_i, .route_en_ns_i, .secure_grp_i,
    .pend_i (pend),
    .clr_o  (clr),
    .rdata_o
  );

  for (genvar i = 0; i < N; i++) begin : g_irq
    irq_st_e st;
    irq_cell u_cell (
      .clk_i, .rst_ni,
      .line_i  (line_i[i]),
      .level_i (level_i[i]),
      .set_i   (set_pend_i[i]),
      .clr_i   (clr[i]),
      .ack_i   (ack_i && (ack_id_i == ID_W'(i))),
      .eoi_i   (eoi_i && (eoi_id_i == ID_W'(i))),
      .st_o    (st)
    );
    assign pend[i]          = st[0];
    assign state_o[2*i +: 2] = st;
  end
endmodule

// File: rtl/irq_pend_chk.sv
module irq_pend_chk #(
  parameter int unsigned N          = 32,
  parameter int unsigned ID_W       = 5,
  parameter int unsigned ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h280
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N-1:0]      secure_grp_i,
  input logic              sec_disable_i,
  input logic              route_en_s_i,
  input logic              route_en_ns_i,
  input logic              ack_i,
  input logic [ID_W-1:0]   ack_id_i,
  input logic              eoi_i,
  input logic [ID_W-1:0]   eoi_id_i,
  input logic              req_i,
  input logic              we_i,
  input logic              ns_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [N-1:0]      rdata_o,
  input logic [2*N-1:0]    state_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) AST_RESET_IDLE: assert (state_o == '0 && rdata_o == '0); // R1
  end

  AST_RD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> rdata_o == '0); // R6
  AST_RD_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i != REG_OFFSET) |=> rdata_o == '0); // R6
  AST_SEC_RAZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && ns_i && !sec_disable_i) |=> (rdata_o & $past(secure_grp_i)) == '0); // R12
  AST_ROUTE_RAZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !route_en_s_i && !route_en_ns_i) |=> rdata_o == '0); // R13

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_ACK_ACTIVATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i && ack_id_i == ID_W'(i) && state_o[2*i +: 2] == 2'b01) |=> state_o[2*i+1]); // R9
    AST_EOI_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eoi_i && eoi_id_i == ID_W'(i) && state_o[2*i+1]) |=> !state_o[2*i+1]); // R10
    AST_ACTIVE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_o[2*i+1] && !(eoi_i && eoi_id_i == ID_W'(i))) |=> state_o[2*i+1]); // R4
  end
endmodule

bind irq_pend_track irq_pend_chk #(
  .N(N), .ID_W(ID_W), .ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)
) u_chk (.*);

// File: tb/tb_irq_pend_track.sv
module tb_irq_pend_track;
  localparam int CLK_HALF = 4; // 125 MHz
  localparam logic [11:0] OFF = 12'h280;

  localparam logic [2:0] OP_EDGE = 3'd0, OP_ACK = 3'd1, OP_EOI = 3'd2, OP_CLR = 3'd3;

  typedef struct packed {
    logic [2:0] op;
    logic [4:0] id;
    logic [1:0] st;
    logic       rd;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VEC [0:15] = '{
    '{OP_EDGE, 5'd3,  2'b01, 1'b1, 4'd2},  // R2
    '{OP_ACK,  5'd3,  2'b10, 1'b0, 4'd9},  // R9
    '{OP_EDGE, 5'd3,  2'b11, 1'b1, 4'd11}, // R11
    '{OP_CLR,  5'd3,  2'b10, 1'b0, 4'd4},  // R4
    '{OP_CLR,  5'd3,  2'b10, 1'b0, 4'd5},  // R5
    '{OP_EOI,  5'd3,  2'b00, 1'b0, 4'd10}, // R10
    '{OP_EDGE, 5'd20, 2'b01, 1'b1, 4'd2},  // R2
    '{OP_CLR,  5'd20, 2'b00, 1'b0, 4'd3},  // R3
    '{OP_EDGE, 5'd20, 2'b01, 1'b1, 4'd2},  // R2
    '{OP_ACK,  5'd20, 2'b10, 1'b0, 4'd9},  // R9
    '{OP_EDGE, 5'd20, 2'b11, 1'b1, 4'd11}, // R11
    '{OP_EOI,  5'd20, 2'b01, 1'b1, 4'd10}, // R10
    '{OP_ACK,  5'd20, 2'b10, 1'b0, 4'd9},  // R9
    '{OP_EOI,  5'd20, 2'b00, 1'b0, 4'd10}, // R10
    '{OP_EOI,  5'd20, 2'b00, 1'b0, 4'd10}, // R10
    '{OP_ACK,  5'd20, 2'b00, 1'b0, 4'd9}   // R9
  };

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [31:0] line_i = '0, level_i = '0, set_pend_i = '0, secure_grp_i = '0;
  logic        sec_disable_i = 1'b0, route_en_s_i = 1'b1, route_en_ns_i = 1'b1;
  logic        ack_i = 1'b0, eoi_i = 1'b0, req_i = 1'b0, we_i = 1'b0, ns_i = 1'b0;
  logic [4:0]  ack_id_i = '0, eoi_id_i = '0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [63:0] state_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] rd;

  always #CLK_HALF clk_i = ~clk_i;

  irq_pend_track dut (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] st(int id);
    return state_o[2*id +: 2];
  endfunction

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic pulse(logic [31:0] m);
    line_i |= m; tick(); line_i &= ~m;
  endtask

  task automatic ack(int id);
    ack_i = 1'b1; ack_id_i = 5'(id); tick(); ack_i = 1'b0;
  endtask

  task automatic eoi(int id);
    eoi_i = 1'b1; eoi_id_i = 5'(id); tick(); eoi_i = 1'b0;
  endtask

  task automatic wr(logic [31:0] m, logic [11:0] a = OFF);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = m; tick();
    req_i = 1'b0; we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rdreg(output logic [31:0] d, input logic [11:0] a = OFF);
    req_i = 1'b1; we_i = 1'b0; addr_i = a; tick(); d = rdata_o; req_i = 1'b0;
  endtask

  initial begin
    #(2 * CLK_HALF * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick();
    chk("R1 state in reset", state_o, '0);
    chk("R1 rdata in reset", rdata_o, '0);
    tick(); rst_ni = 1'b1; tick();
    chk("R1 state after reset", state_o, '0);
    rdreg(rd);
    chk("R1 read after reset", rd, '0);

    foreach (VEC[k]) begin
      case (VEC[k].op)
        OP_EDGE: pulse(32'd1 << VEC[k].id);
        OP_ACK:  ack(VEC[k].id);
        OP_EOI:  eoi(VEC[k].id);
        default: wr(32'd1 << VEC[k].id);
      endcase
      chk($sformatf("R%0d vec %0d state", VEC[k].req, k), st(VEC[k].id), VEC[k].st);
      rdreg(rd);
      chk($sformatf("R%0d vec %0d read", VEC[k].req, k), rd[VEC[k].id], VEC[k].rd);
    end

    // R2: held line does not re-trigger
    line_i[8] = 1'b1; tick(); tick();
    wr(32'h100);
    tick();
    chk("R2 held line no retrigger", st(8), 2'b00);
    line_i[8] = 1'b0; tick();

    // R6 offset decode, R3 zero bits and multi-bit clear
    pulse(32'h20);
    rdreg(rd, 12'h284);
    chk("R6 read wrong offset", rd, '0);
    wr(32'h20, 12'h200);
    chk("R6 write wrong offset", st(5), 2'b01);
    wr(32'h0);
    chk("R3 zero mask", st(5), 2'b01);
    wr(32'h20);
    pulse(32'h4000_0006);
    wr(32'h4000_0002);
    chk("R3 bit1 cleared", st(1), 2'b00);
    chk("R3 bit30 cleared", st(30), 2'b00);
    chk("R3 bit2 kept", st(2), 2'b01);
    rdreg(rd);
    chk("R6 read map", rd, 32'h4);
    wr(32'h4);

    // R7 level line
    level_i[17] = 1'b1; line_i[17] = 1'b1; tick();
    chk("R7 level pending", st(17), 2'b01);
    wr(32'h2_0000);
    chk("R7 clear while high", st(17), 2'b01);
    line_i[17] = 1'b0; tick();
    chk("R7 line dropped", st(17), 2'b00);

    // R8 software latch
    level_i[18] = 1'b1;
    set_pend_i[18] = 1'b1; tick(); set_pend_i[18] = 1'b0;
    chk("R8 latch set", st(18), 2'b01);
    wr(32'h4_0000);
    chk("R8 latch cleared", st(18), 2'b00);
    set_pend_i[18] = 1'b1; tick(); set_pend_i[18] = 1'b0;
    line_i[18] = 1'b1; tick();
    wr(32'h4_0000);
    chk("R8 clear with line high", st(18), 2'b01);
    line_i[18] = 1'b0; tick();
    chk("R8 latch gone", st(18), 2'b00);

    // R14 collisions
    line_i[9] = 1'b1; req_i = 1'b1; we_i = 1'b1; addr_i = OFF; wdata_i = 32'h200; tick();
    req_i = 1'b0; we_i = 1'b0; line_i[9] = 1'b0;
    chk("R14 edge beats clear", st(9), 2'b01);
    set_pend_i[9] = 1'b1; req_i = 1'b1; we_i = 1'b1; wdata_i = 32'h200; tick();
    req_i = 1'b0; we_i = 1'b0; set_pend_i[9] = 1'b0;
    chk("R14 set beats clear", st(9), 2'b01);
    wr(32'h200);
    chk("R14 later clear", st(9), 2'b00);

    // R12 security filter
    secure_grp_i[7] = 1'b1;
    pulse(32'hC0);
    ns_i = 1'b1;
    rdreg(rd);
    chk("R12 ns read secure bit", rd & 32'hC0, 32'h40);
    wr(32'h80);
    chk("R12 ns clear ignored", st(7), 2'b01);
    sec_disable_i = 1'b1;
    rdreg(rd);
    chk("R12 security disabled read", rd & 32'hC0, 32'hC0);
    sec_disable_i = 1'b0; ns_i = 1'b0;
    wr(32'hC0);
    chk("R12 secure clear", st(7), 2'b00);
    chk("R12 ns bit clear", st(6), 2'b00);

    // R13 routing disabled
    route_en_ns_i = 1'b0;
    pulse(32'h800);
    rdreg(rd);
    chk("R13 read hidden", rd[11], 1'b0);
    wr(32'h800);
    chk("R13 write ignored", st(11), 2'b01);
    route_en_ns_i = 1'b1;
    rdreg(rd);
    chk("R13 read visible", rd[11], 1'b1);
    wr(32'h800);
    chk("R13 clear works", st(11), 2'b00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule